// File: doc/BRIEF.md
# Boost PWM Gate Controller with Minimum Off-Time

This block generates the switch command for a boost power stage that runs in continuous conduction mode. Each switching period opens with the switch held off for a fixed minimum off-time, while an internal digital ramp is held at zero. Once that window closes, the ramp climbs at a fixed slope. The switch turns on when the ramp reaches a reference word, which stands for the averaged inductor current. The switch then stays on until the next period strobe. As a result, the off share of each period grows with the reference.

A peak-current comparator flag is filtered so that only a sustained assertion counts. When an accepted trip occurs, the switch is latched off for the remainder of the period. The minimum off-time window clears both the trip latch and the on latch, and it overrides every other input. An enable input drops the switch command with no clock edge involved and disarms the period until the next strobe. The ramp slope is derived from the nominal period length, so that the ramp saturates one minimum off-time before the period ends.

Top module: `boost_pwm_gate`

## Requirements
- R1: While reset is held and on the first cycles after it, `gate_on` and `ramp_act` are 0.
- R2: After the clock edge that samples `cyc_start` high, `gate_on` is 0 and `ramp_act` is 0 for TOFF_CYC clock periods. `ramp_act` becomes 1 after the TOFF_CYC-th edge following the strobe edge.
- R3: With `ref_lvl` = N below all ones, `gate_on` rises after edge TOFF_CYC + N*DIV + 1, where edges are counted from the strobe edge and DIV = (CLK_PER_CYC - 2*TOFF_CYC) / (2^RW - 1). It then stays 1 until the edge that samples the next strobe, and falls at that edge.
- R4: With `ref_lvl` all ones (full scale), `gate_on` stays 0 for the whole period, which gives 0 % duty.
- R5: With `ref_lvl` = 0 and strobes spaced CLK_PER_CYC clocks apart, `gate_on` is 1 for exactly CLK_PER_CYC - TOFF_CYC - 1 clocks of each period. This is the maximum duty.
- R6: If `pcl_raw` is sampled high on DEGL_CYC consecutive edges during the on-time, `gate_on` falls after the next edge. It stays 0 for the rest of the period, even after `pcl_raw` drops.
- R7: A `pcl_raw` pulse that is sampled high on fewer than DEGL_CYC consecutive edges has no effect on `gate_on`.
- R8: A strobe clears a latched peak-current trip, so the next period turns on at the time given in R3.
- R9: `run_en` = 0 forces `gate_on` to 0 with no clock edge involved. From the next edge on, `ramp_act` is 0. After `run_en` returns to 1, `gate_on` stays 0 until a new strobe starts a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start | input | 1 | One-clock strobe that begins a switching period |
| ref_lvl | input | RW | Current-loop reference word; all ones means never turn on |
| pcl_raw | input | 1 | Unfiltered peak-current comparator flag, active high |
| run_en | input | 1 | Enable; low forces the switch off and disarms the period |
| gate_on | output | 1 | Switch command, 1 = on |
| ramp_act | output | 1 | 1 while the ramp is released and rising or saturated |

## Verification
Most internal errors show up as a misplaced rising edge of `gate_on`. If the off-time counter, the ramp prescaler or the ramp counter holds a wrong value, the turn-on edge shifts by one or more clocks (by DIV clocks per ramp step) within the same period. The bench therefore measures that edge exactly for several reference words. A trip or on latch that fails to clear, or a filter counter that does not restart, becomes visible as a missing turn-on in the next period, or as a trip one edge early or late. The bench places its pulses within one sample of the acceptance length, so that a one-edge error in the filter is caught.

// File: rtl/pwm_gate_pkg.sv
// Package: shared types and derived constants for the boost PWM gate block.
// Assumes parameters are positive and CLK_PER_CYC > 2*TOFF_CYC.
package pwm_gate_pkg;

    // State of the two set/reset latches in one period.
    typedef struct packed {
        logic on_q;   // ramp crossed the reference
        logic pcl_q;  // accepted peak-current trip
    } gate_latch_t;

    // Clocks per ramp step so that the ramp saturates one off-time before period end.
    function automatic int ramp_div(input int per_cyc, input int toff, input int rw);
        int steps;
        int d;
        steps = (1 << rw) - 1;
        d = (per_cyc - 2 * toff) / steps;
        return (d < 1) ? 1 : d;
    endfunction

    // Width of a counter that holds values 0..maxval.
    function automatic int cnt_width(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/min_off_timer.sv
// Minimum off-time generator: loads TOFF_CYC on a period strobe and counts down.
// off_act is high while the count is nonzero, i.e. for TOFF_CYC clocks after the strobe edge.
// Assumes TOFF_CYC >= 1. A strobe during the window restarts it.
module min_off_timer
    import pwm_gate_pkg::*;
#(
    parameter int TOFF_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic off_act
);
    localparam int CW = cnt_width(TOFF_CYC);
    localparam logic [CW-1:0] LOAD = CW'(TOFF_CYC);

    logic [CW-1:0] remain;

    // Load on strobe, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign off_act = (remain != '0);

endmodule

// File: rtl/ramp_counter.sv
// Digital ramp: held at zero while hold is high, then advances one step every DIV clocks
// and saturates at all ones. Armed by a strobe, disarmed by abort.
// Assumes start and hold arrive together from the off-time generator.
module ramp_counter
    import pwm_gate_pkg::*;
#(
    parameter int RW  = 8,
    parameter int DIV = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          hold,
    input  logic          abort,
    output logic [RW-1:0] ramp,
    output logic          active
);
    localparam int PW = cnt_width(DIV - 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
    localparam logic [RW-1:0] RAMP_MAX = '1;

    logic          armed;
    logic [PW-1:0] pre;

    // Armed from a strobe until an abort.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (abort)
            armed <= 1'b0;
        else if (start)
            armed <= 1'b1;
    end

    // Prescaler and ramp value, cleared whenever the ramp is not released.
    always_ff @(posedge clk) begin
        if (!rst_n || start || hold || !armed) begin
            pre  <= '0;
            ramp <= '0;
        end else if (pre == PRE_LAST) begin
            pre <= '0;
            if (ramp != RAMP_MAX)
                ramp <= ramp + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assign active = armed & ~hold;

endmodule

// File: rtl/pcl_filter.sv
// Peak-current deglitch filter: raw flag must be sampled high on DEGL_CYC consecutive
// edges before ok goes high; any low sample restarts the count.
// Assumes DEGL_CYC >= 1.
module pcl_filter
    import pwm_gate_pkg::*;
#(
    parameter int DEGL_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic ok
);
    localparam int CW = cnt_width(DEGL_CYC);
    localparam logic [CW-1:0] FULL = CW'(DEGL_CYC);

    logic [CW-1:0] run_len;

    // Count consecutive high samples, saturating at the acceptance length.
    always_ff @(posedge clk) begin
        if (!rst_n || !raw)
            run_len <= '0;
        else if (run_len != FULL)
            run_len <= run_len + 1'b1;
    end

    assign ok = (run_len == FULL);

endmodule

// File: rtl/gate_latches.sv
// The on latch and the peak-current latch. clr has top priority over both sets.
// Assumes set inputs are synchronous to clk.
module gate_latches
    import pwm_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        set_on,
    input  logic        set_pcl,
    output gate_latch_t lat
);
    // Reset-dominant set/reset latches, one update per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lat <= '0;
        end else begin
            if (set_on)
                lat.on_q <= 1'b1;
            if (set_pcl)
                lat.pcl_q <= 1'b1;
        end
    end

endmodule

// File: rtl/boost_pwm_gate.sv
// Top: trailing-edge-on PWM for a CCM boost stage. Each period begins with a forced
// off-time, then a ramp rises and turns the switch on at the reference crossing.
// A filtered peak-current trip holds the switch off for the rest of the period.
// run_en low forces the switch off combinationally. Assumes cyc_start is one clock wide.
module boost_pwm_gate
    import pwm_gate_pkg::*;
#(
    parameter int RW          = 8,
    parameter int CLK_PER_CYC = 1538,
    parameter int TOFF_CYC    = 60,
    parameter int DEGL_CYC    = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_start,
    input  logic [RW-1:0] ref_lvl,
    input  logic          pcl_raw,
    input  logic          run_en,
    output logic          gate_on,
    output logic          ramp_act
);
    localparam int DIV = ramp_div(CLK_PER_CYC, TOFF_CYC, RW);
    localparam logic [RW-1:0] FULL_SCALE = '1;

    logic          toff_act;
    logic [RW-1:0] ramp_val;
    logic          ramp_live;
    logic          pcl_ok;
    logic          crossed;
    logic          latch_clr;
    logic          pcl_held;
    gate_latch_t   lat_q;

    min_off_timer #(.TOFF_CYC(TOFF_CYC)) u_toff (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .off_act (toff_act)
    );

    ramp_counter #(.RW(RW), .DIV(DIV)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cyc_start),
        .hold   (toff_act),
        .abort  (~run_en),
        .ramp   (ramp_val),
        .active (ramp_live)
    );

    pcl_filter #(.DEGL_CYC(DEGL_CYC)) u_pcl (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (pcl_raw),
        .ok    (pcl_ok)
    );

    // Crossing: ramp released and at or above a reference below full scale.
    always_comb begin
        crossed = ramp_live && (ref_lvl != FULL_SCALE) && (ramp_val >= ref_lvl);
    end

    // Latch clear: off-time window, new strobe, or disable.
    always_comb begin
        latch_clr = toff_act | cyc_start | ~run_en;
    end

    gate_latches u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (latch_clr),
        .set_on  (crossed),
        .set_pcl (pcl_ok),
        .lat     (lat_q)
    );

    assign pcl_held = lat_q.pcl_q;
    assign gate_on  = lat_q.on_q & ~pcl_held & ~toff_act & run_en;
    assign ramp_act = ramp_live;

endmodule

// File: rtl/pwm_gate_checker.sv
// Assertion checker for boost_pwm_gate, attached by bind below.
module pwm_gate_checker #(
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_start,
    input logic          run_en,
    input logic [RW-1:0] ref_lvl,
    input logic          gate_on,
    input logic          ramp_act,
    input logic          toff_act,
    input logic          pcl_held,
    input logic [RW-1:0] ramp_val
);
    // R2: no switch-on and no ramp release inside the off-time window.
    p_off_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        toff_act |-> (!gate_on && !ramp_act));

    // R2: ramp is zero on the cycle after any off-time cycle.
    p_ramp_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        toff_act |=> (ramp_val == '0));

    // R3: a strobe turns the switch off on the following cycle.
    p_strobe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !gate_on);

    // R4: the switch never rises when the reference was full scale.
    p_fullscale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> ($past(ref_lvl) != {RW{1'b1}}));

    // R6: a held trip keeps the switch off.
    p_trip_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pcl_held |-> !gate_on);

    // R9: disable forces the switch off and disarms the ramp on the next cycle.
    p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !gate_on);
    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cyc_start) |=> !ramp_act);

endmodule

bind boost_pwm_gate pwm_gate_checker #(.RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .run_en    (run_en),
    .ref_lvl   (ref_lvl),
    .gate_on   (gate_on),
    .ramp_act  (ramp_act),
    .toff_act  (toff_act),
    .pcl_held  (pcl_held),
    .ramp_val  (ramp_val)
);

// File: tb/boost_pwm_gate_test.sv
// Directed bench for boost_pwm_gate: one task per scenario, each checking its own results.
module boost_pwm_gate_test;
    localparam int RW   = 8;
    localparam int PER  = 1538;
    localparam int TOFF = 60;
    localparam int DEGL = 20;
    localparam int DIV  = (PER - 2 * TOFF) / ((1 << RW) - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start = 1'b0;
    logic [RW-1:0] ref_lvl = '0;
    logic          pcl_raw = 1'b0;
    logic          run_en = 1'b1;
    logic          gate_on;
    logic          ramp_act;

    int total = 0;
    int bad = 0;
    int clk_cnt = 0;

    boost_pwm_gate #(.RW(RW), .CLK_PER_CYC(PER), .TOFF_CYC(TOFF), .DEGL_CYC(DEGL)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ref_lvl(ref_lvl),
        .pcl_raw(pcl_raw), .run_en(run_en), .gate_on(gate_on), .ramp_act(ramp_act)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        clk_cnt <= clk_cnt + 1;
        if (clk_cnt > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=150000", clk_cnt);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe at the current negedge; returns at the negedge after the strobe edge (index 0).
    task automatic strobe();
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    // Advance to sample index upto; return first index where gate_on was 1 (-1 if none).
    task automatic watch_rise(input int from, input int upto, output int first_hi);
        first_hi = -1;
        for (int j = from + 1; j <= upto; j++) begin
            @(negedge clk);
            if (gate_on && first_hi < 0) first_hi = j;
        end
    endtask

    task automatic t_reset_r1();
        chk(gate_on == 1'b0, "R1 gate in reset", gate_on, 0);
        chk(ramp_act == 1'b0, "R1 ramp_act in reset", ramp_act, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(gate_on == 1'b0, "R1 gate after reset", gate_on, 0);
        chk(ramp_act == 1'b0, "R1 ramp_act after reset", ramp_act, 0);
    endtask

    // R2 and R3: off window, ramp release and turn-on point for reference n.
    task automatic t_turn_on_r3(input int n);
        int first_ramp;
        int first_hi;
        bit gate_in_off;
        ref_lvl = RW'(n);
        strobe();
        first_ramp = -1;
        gate_in_off = gate_on;
        for (int j = 1; j <= TOFF; j++) begin
            @(negedge clk);
            if (j < TOFF && gate_on) gate_in_off = 1'b1;
            if (ramp_act && first_ramp < 0) first_ramp = j;
        end
        chk(!gate_in_off, "R2 gate low in off window", gate_in_off, 0);
        chk(first_ramp == TOFF, "R2 ramp release index", first_ramp, TOFF);
        watch_rise(TOFF, TOFF + n * DIV + 5, first_hi);
        chk(first_hi == TOFF + n * DIV + 1, "R3 turn-on index", first_hi, TOFF + n * DIV + 1);
        chk(gate_on == 1'b1, "R3 gate stays on", gate_on, 1);
    endtask

    // R4: full-scale reference never turns on over a whole period.
    task automatic t_fullscale_r4();
        int hi_cnt = 0;
        ref_lvl = '1;
        strobe();
        chk(gate_on == 1'b0, "R3 gate falls at strobe edge", gate_on, 0);
        for (int j = 1; j < PER; j++) begin
            @(negedge clk);
            if (gate_on) hi_cnt++;
        end
        chk(hi_cnt == 0, "R4 full-scale on clocks", hi_cnt, 0);
    endtask

    // R5: maximum duty with reference zero over two back-to-back periods.
    task automatic t_max_duty_r5();
        ref_lvl = '0;
        for (int p = 0; p < 2; p++) begin
            int hi_cnt = 0;
            strobe();
            if (gate_on) hi_cnt++;
            for (int j = 1; j < PER; j++) begin
                @(negedge clk);
                if (gate_on) hi_cnt++;
            end
            chk(hi_cnt == PER - TOFF - 1, "R5 on clocks per period", hi_cnt, PER - TOFF - 1);
        end
    endtask

    // R6 and R8: accepted trip cuts the period; next strobe clears it.
    task automatic t_trip_r6();
        int first_hi;
        ref_lvl = '0;
        strobe();
        watch_rise(0, 100, first_hi);
        pcl_raw = 1'b1;
        for (int j = 101; j <= 100 + DEGL; j++) @(negedge clk);
        chk(gate_on == 1'b1, "R6 gate before acceptance", gate_on, 1);
        @(negedge clk);
        chk(gate_on == 1'b0, "R6 gate cut after acceptance", gate_on, 0);
        pcl_raw = 1'b0;
        watch_rise(101 + DEGL, 400, first_hi);
        chk(first_hi == -1, "R6 stays off after flag drops", first_hi, -1);
        strobe();
        watch_rise(0, TOFF + 5, first_hi);
        chk(first_hi == TOFF + 1, "R8 turn-on after trip period", first_hi, TOFF + 1);
    endtask

    // R7: a pulse one sample short of acceptance changes nothing.
    task automatic t_short_pulse_r7();
        int drops = 0;
        ref_lvl = '0;
        strobe();
        repeat (100) @(negedge clk);
        pcl_raw = 1'b1;
        repeat (DEGL - 1) @(negedge clk);
        pcl_raw = 1'b0;
        for (int j = 0; j < 100; j++) begin
            @(negedge clk);
            if (!gate_on) drops++;
        end
        chk(drops == 0, "R7 short pulse low clocks", drops, 0);
    endtask

    // R9: disable forces off with no edge, disarms, and needs a new strobe.
    task automatic t_disable_r9();
        int first_hi;
        ref_lvl = '0;
        strobe();
        repeat (100) @(negedge clk);
        chk(gate_on == 1'b1, "R9 gate on before disable", gate_on, 1);
        run_en = 1'b0;
        #1;
        chk(gate_on == 1'b0, "R9 gate off without edge", gate_on, 0);
        @(negedge clk);
        chk(ramp_act == 1'b0, "R9 ramp disarmed", ramp_act, 0);
        run_en = 1'b1;
        watch_rise(0, 200, first_hi);
        chk(first_hi == -1, "R9 stays off after re-enable", first_hi, -1);
        strobe();
        watch_rise(0, TOFF + 5, first_hi);
        chk(first_hi == TOFF + 1, "R9 turn-on after new strobe", first_hi, TOFF + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        t_turn_on_r3(0);
        t_turn_on_r3(10);
        t_turn_on_r3(100);
        t_fullscale_r4();
        t_max_duty_r5();
        t_trip_r6();
        t_short_pulse_r7();
        t_disable_r9();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule